// File: doc/BRIEF.md
# Bus Master Security Gate

This block sits between one bus-mastering device, such as a DMA engine, and the system interconnect. Each request the master issues is checked against the security attributes of the addressed region. The gate then takes one of four actions. It can forward the request tagged secure, forward it tagged non-secure, complete it locally as a silent read-as-zero / write-ignored access, or complete it locally with an error.

The region attributes come from an external combinational lookup. The gate presents the request address on `lk_addr_o` and receives two flags back: exempt and non-secure. Three static inputs set the policy:

- one states that the master runs non-secure;
- one selects error responses instead of silent completion for blocked requests;
- one clears the sticky interrupt.

The interrupt records that at least one request was rejected with an error.

There is only one transaction in flight at a time. The upstream response is produced locally for blocked requests, and is relayed from the downstream response for forwarded ones.

Top module: `bm_sec_gate`

## Requirements
- R1: When the lookup reports the address as exempt, the request is forwarded downstream. `dn_secure_o` is 0 (non-secure) if `cfg_nonsec_i` is high, and 1 (secure) if it is low. This holds whatever the non-secure flag says.
- R2: When the address is not exempt but the region is non-secure, the request is forwarded with `dn_secure_o`=0 regardless of `cfg_nonsec_i`.
- R3: A non-exempt secure region accessed while `cfg_nonsec_i` is low is forwarded with `dn_secure_o`=1.
- R4: A non-exempt secure region accessed while `cfg_nonsec_i` is high is blocked. With `cfg_sec_resp_i` low, it completes with `up_rsp_err_o`=0 and all-zero read data, and no downstream request is issued.
- R5: In the blocked case with `cfg_sec_resp_i` high, the request completes with `up_rsp_err_o`=1 and zero data, and no downstream request is issued.
- R6: An error-completed block sets a sticky status that drives `irq_o` high from the cycle after the handshake until it is cleared. It is not set if `irq_clear_i` is high at the handshake.
- R7: While `irq_clear_i` is high, `irq_o` is low in the same cycle and the status is cleared. A silent (read-as-zero) block never raises `irq_o`.
- R8: After reset, `irq_o`=0, `up_req_ready_o`=1, `dn_req_valid_o`=0 and `up_rsp_valid_o`=0.
- R9: `up_size_i` encodes 2^n bytes (0=1, 1=2, 2=4, 3=8). Only the low 2^n byte lanes (little-endian) of forwarded write data and of returned read data are kept; upper lanes are zero.
- R10: The policy inputs are sampled at the request handshake. Changing them while the request is pending downstream does not alter its tag or outcome.
- R11: There is only one request outstanding: `up_req_ready_o` is low from handshake until the response. The downstream request holds while `dn_req_ready_i` is low. For forwarded requests, `dn_err_i` is relayed to `up_rsp_err_o` without touching `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_nonsec_i | input | 1 | Master is non-secure |
| cfg_sec_resp_i | input | 1 | Blocked requests respond with error instead of RAZ/WI |
| irq_clear_i | input | 1 | Clear and suppress the sticky interrupt |
| irq_o | output | 1 | Sticky blocked-with-error interrupt |
| up_req_valid_i | input | 1 | Master request valid |
| up_req_ready_o | output | 1 | Gate can accept a request |
| up_addr_i | input | AW | Request address |
| up_write_i | input | 1 | 1 = write, 0 = read |
| up_size_i | input | SW | Log2 of access bytes |
| up_wdata_i | input | DW | Write data, little-endian lanes |
| up_rsp_valid_o | output | 1 | One-cycle response strobe |
| up_rsp_rdata_o | output | DW | Read data |
| up_rsp_err_o | output | 1 | Error response |
| lk_addr_o | output | AW | Address to region lookup |
| lk_exempt_i | input | 1 | Region is exempt from checking |
| lk_nonsec_i | input | 1 | Region is non-secure |
| dn_req_valid_o | output | 1 | Downstream request valid |
| dn_req_ready_i | input | 1 | Downstream accepts request |
| dn_addr_o | output | AW | Forwarded address |
| dn_write_o | output | 1 | Forwarded write flag |
| dn_size_o | output | SW | Forwarded size |
| dn_wdata_o | output | DW | Forwarded, lane-masked write data |
| dn_secure_o | output | 1 | 1 = secure, 0 = non-secure |
| dn_rsp_valid_i | input | 1 | Downstream response valid |
| dn_rdata_i | input | DW | Downstream read data |
| dn_err_i | input | 1 | Downstream error |

## Verification
A wrong action decision shows up one cycle after the handshake, in one of three ways:

- a blocked request produces a downstream strobe;
- a forwarded one gets a local response;
- the wrong `dn_secure_o` tag is seen by the downstream model.

A corrupted sticky status is visible on `irq_o` in the cycle right after the deciding handshake, and stays visible until a clear. Lane-mask or relay faults appear in the single response beat, so every response is compared against a reference decision and a masked data pattern.

// File: rtl/bmsg_pkg.sv
package bmsg_pkg;
  typedef enum logic [1:0] {
    ACT_ABORT   = 2'd0,
    ACT_RAZWI   = 2'd1,
    ACT_PASS_S  = 2'd2,
    ACT_PASS_NS = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DREQ  = 2'd1,
    ST_DWAIT = 2'd2,
    ST_RSP   = 2'd3
  } st_e;
endpackage

// File: rtl/bmsg_decide.sv
module bmsg_decide
  import bmsg_pkg::*;
(
  input  logic exempt_i,
  input  logic nonsec_rgn_i,
  input  logic mst_ns_i,
  input  logic err_rsp_i,
  output act_e act_o
);
  always_comb begin
    if (exempt_i)          act_o = mst_ns_i ? ACT_PASS_NS : ACT_PASS_S;
    else if (nonsec_rgn_i) act_o = ACT_PASS_NS;
    else if (!mst_ns_i)    act_o = ACT_PASS_S;
    else if (err_rsp_i)    act_o = ACT_ABORT;
    else                   act_o = ACT_RAZWI;
  end
endmodule

// File: rtl/bmsg_lane_mask.sv
module bmsg_lane_mask #(
  parameter int DW = 64,
  parameter int SW = 2
) (
  input  logic [SW-1:0] size_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign data_o[b*8 +: 8] = (32'(b) < (32'd1 << size_i)) ? data_i[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/bmsg_irq.sv
module bmsg_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= 1'b0;
    else if (clr_i)  st_q <= 1'b0;
    else if (set_i)  st_q <= 1'b1;
  end

  // clear acts in the same cycle
  assign irq_o = st_q & ~clr_i;

  // R7
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !st_q);

  // R6
  set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q) |-> $past(set_i && !clr_i));

  // R6
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q && !clr_i) |=> st_q);
endmodule

// File: rtl/bm_sec_gate.sv
module bm_sec_gate
  import bmsg_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  localparam int NB = DW / 8,
  localparam int SW = $clog2($clog2(NB) + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_nonsec_i,
  input  logic          cfg_sec_resp_i,
  input  logic          irq_clear_i,
  output logic          irq_o,
  input  logic          up_req_valid_i,
  output logic          up_req_ready_o,
  input  logic [AW-1:0] up_addr_i,
  input  logic          up_write_i,
  input  logic [SW-1:0] up_size_i,
  input  logic [DW-1:0] up_wdata_i,
  output logic          up_rsp_valid_o,
  output logic [DW-1:0] up_rsp_rdata_o,
  output logic          up_rsp_err_o,
  output logic [AW-1:0] lk_addr_o,
  input  logic          lk_exempt_i,
  input  logic          lk_nonsec_i,
  output logic          dn_req_valid_o,
  input  logic          dn_req_ready_i,
  output logic [AW-1:0] dn_addr_o,
  output logic          dn_write_o,
  output logic [SW-1:0] dn_size_o,
  output logic [DW-1:0] dn_wdata_o,
  output logic          dn_secure_o,
  input  logic          dn_rsp_valid_i,
  input  logic [DW-1:0] dn_rdata_i,
  input  logic          dn_err_i
);
  st_e           st_q;
  act_e          act;
  logic          hs;
  logic [AW-1:0] addr_q;
  logic          wr_q, sec_q, err_q;
  logic [SW-1:0] size_q;
  logic [DW-1:0] wdata_q, rdata_q, wdata_m, rdata_m;

  assign lk_addr_o      = up_addr_i;
  assign up_req_ready_o = (st_q == ST_IDLE);
  assign hs             = up_req_valid_i && up_req_ready_o;

  bmsg_decide u_decide (
    .exempt_i    (lk_exempt_i),
    .nonsec_rgn_i(lk_nonsec_i),
    .mst_ns_i    (cfg_nonsec_i),
    .err_rsp_i   (cfg_sec_resp_i),
    .act_o       (act)
  );

  bmsg_lane_mask #(.DW(DW), .SW(SW)) u_wmask (
    .size_i(up_size_i), .data_i(up_wdata_i), .data_o(wdata_m)
  );

  bmsg_lane_mask #(.DW(DW), .SW(SW)) u_rmask (
    .size_i(size_q), .data_i(dn_rdata_i), .data_o(rdata_m)
  );

  bmsg_irq u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (hs && (act == ACT_ABORT)),
    .clr_i (irq_clear_i),
    .irq_o (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      size_q  <= '0;
      wdata_q <= '0;
      sec_q   <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (hs) begin
          addr_q  <= up_addr_i;
          wr_q    <= up_write_i;
          size_q  <= up_size_i;
          wdata_q <= wdata_m;
          rdata_q <= '0;
          err_q   <= 1'b0;
          case (act)
            ACT_PASS_S:  begin sec_q <= 1'b1; st_q <= ST_DREQ; end
            ACT_PASS_NS: begin sec_q <= 1'b0; st_q <= ST_DREQ; end
            ACT_ABORT:   begin err_q <= 1'b1; st_q <= ST_RSP;  end
            default:     st_q <= ST_RSP;
          endcase
        end
        ST_DREQ: if (dn_req_ready_i) st_q <= ST_DWAIT;
        ST_DWAIT: if (dn_rsp_valid_i) begin
          rdata_q <= wr_q ? '0 : rdata_m;
          err_q   <= dn_err_i;
          st_q    <= ST_RSP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign dn_req_valid_o = (st_q == ST_DREQ);
  assign dn_addr_o      = addr_q;
  assign dn_write_o     = wr_q;
  assign dn_size_o      = size_q;
  assign dn_wdata_o     = wdata_q;
  assign dn_secure_o    = sec_q;
  assign up_rsp_valid_o = (st_q == ST_RSP);
  assign up_rsp_rdata_o = rdata_q;
  assign up_rsp_err_o   = err_q;

  // R11
  dn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_req_valid_o && !dn_req_ready_i) |=>
      (dn_req_valid_o && $stable(dn_addr_o) && $stable(dn_secure_o)));

  // R4 R5
  blk_nofwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && (act == ACT_ABORT || act == ACT_RAZWI)) |=>
      (up_rsp_valid_o && !dn_req_valid_o && (up_rsp_rdata_o == '0)));

  // R5
  abort_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && act == ACT_ABORT) |=> up_rsp_err_o);

  // R2
  ns_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && !lk_exempt_i && lk_nonsec_i) |=> (dn_req_valid_o && !dn_secure_o));

  // R11
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_rsp_valid_o |=> (!up_rsp_valid_o && up_req_ready_o));
endmodule

// File: tb/bm_sec_gate_tb_top.sv
module bm_sec_gate_tb_top;
  localparam logic [63:0] PAT = 64'h8877_6655_4433_2211;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ns = 1'b0, cfg_er = 1'b0, irq_clr = 1'b0;
  logic        irq;
  logic        up_valid = 1'b0, up_ready, up_wr = 1'b0;
  logic [31:0] up_addr = '0;
  logic [1:0]  up_size = '0;
  logic [63:0] up_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [31:0] lk_addr;
  logic        dn_valid, dn_ready = 1'b1, dn_wr, dn_sec, dn_err = 1'b0;
  logic [31:0] dn_addr;
  logic [1:0]  dn_size;
  logic [63:0] dn_wdata;
  logic        rsp_pend;
  int          cap_cnt;
  logic        cap_sec;
  logic [63:0] cap_wdata;
  int          tests = 0, fails = 0;

  always #5 clk = ~clk;

  bm_sec_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_nonsec_i(cfg_ns), .cfg_sec_resp_i(cfg_er), .irq_clear_i(irq_clr), .irq_o(irq),
    .up_req_valid_i(up_valid), .up_req_ready_o(up_ready), .up_addr_i(up_addr),
    .up_write_i(up_wr), .up_size_i(up_size), .up_wdata_i(up_wdata),
    .up_rsp_valid_o(rsp_valid), .up_rsp_rdata_o(rsp_rdata), .up_rsp_err_o(rsp_err),
    .lk_addr_o(lk_addr), .lk_exempt_i(lk_addr[31]), .lk_nonsec_i(lk_addr[30]),
    .dn_req_valid_o(dn_valid), .dn_req_ready_i(dn_ready), .dn_addr_o(dn_addr),
    .dn_write_o(dn_wr), .dn_size_o(dn_size), .dn_wdata_o(dn_wdata), .dn_secure_o(dn_sec),
    .dn_rsp_valid_i(rsp_pend), .dn_rdata_i(PAT), .dn_err_i(dn_err)
  );

  // downstream model: responds one cycle after acceptance
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_pend <= 1'b0; cap_cnt <= 0; cap_sec <= 1'b0; cap_wdata <= '0;
    end else begin
      rsp_pend <= dn_valid && dn_ready;
      if (dn_valid && dn_ready) begin
        cap_cnt   <= cap_cnt + 1;
        cap_sec   <= dn_sec;
        cap_wdata <= dn_wdata;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // 0 abort, 1 razwi, 2 pass secure, 3 pass non-secure
  function automatic int ref_act(input logic ex, input logic nsr, input logic mns, input logic er);
    if (ex) return mns ? 3 : 2;
    if (nsr) return 3;
    if (!mns) return 2;
    return er ? 0 : 1;
  endfunction

  function automatic logic [63:0] lane_keep(input logic [63:0] d, input int sz);
    logic [63:0] r = '0;
    for (int b = 0; b < (1 << sz); b++) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  task automatic do_txn(input logic [31:0] a, input logic w, input logic [1:0] sz,
                        input logic [63:0] wd, output logic [63:0] rd, output logic er,
                        output int fwd);
    int c0, n;
    @(negedge clk);
    up_valid = 1'b1; up_addr = a; up_wr = w; up_size = sz; up_wdata = wd;
    c0 = cap_cnt;
    @(posedge clk);
    @(negedge clk);
    up_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
    rd = rsp_rdata; er = rsp_err; fwd = cap_cnt - c0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); irq_clr = 1'b1; #1;
    chk("R7 clear same cycle", {63'd0, irq}, 64'd0);
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 irq", {63'd0, irq}, 64'd0);
    chk("R8 ready", {63'd0, up_ready}, 64'd1);
    chk("R8 dn valid", {63'd0, dn_valid}, 64'd0);
    chk("R8 rsp valid", {63'd0, rsp_valid}, 64'd0);
  endtask

  // R1 R2 R3 R4 R5 R6: full decision matrix
  task automatic t_matrix();
    logic [63:0] rd; logic er; int fwd, act;
    for (int i = 0; i < 16; i++) begin
      for (int w = 0; w < 2; w++) begin
        pulse_clear();
        cfg_ns = i[1]; cfg_er = i[0];
        act = ref_act(i[3], i[2], i[1], i[0]);
        do_txn({i[3], i[2], 30'h100}, w[0], 2'd3, 64'hA5A5_0000_1234_5678, rd, er, fwd);
        chk("R1R2R3 forwarded", 64'(fwd), (act >= 2) ? 64'd1 : 64'd0);
        if (act >= 2) chk("R1R2R3 secure tag", {63'd0, cap_sec}, (act == 2) ? 64'd1 : 64'd0);
        chk("R4R5 err", {63'd0, er}, (act == 0) ? 64'd1 : 64'd0);
        chk("R4 rdata", rd, (act >= 2 && w == 0) ? PAT : 64'd0);
        chk("R6 irq", {63'd0, irq}, (act == 0) ? 64'd1 : 64'd0);
      end
    end
  endtask

  task automatic t_irq();
    logic [63:0] rd; logic er; int fwd;
    pulse_clear();
    cfg_ns = 1'b1; cfg_er = 1'b0;
    do_txn(32'h0000_0040, 1'b0, 2'd2, '0, rd, er, fwd);
    chk("R7 razwi no irq", {63'd0, irq}, 64'd0);
    cfg_er = 1'b1;
    do_txn(32'h0000_0040, 1'b1, 2'd2, '1, rd, er, fwd);
    chk("R6 abort sets irq", {63'd0, irq}, 64'd1);
    do_txn(32'h4000_0040, 1'b0, 2'd2, '0, rd, er, fwd);
    chk("R6 sticky over pass", {63'd0, irq}, 64'd1);
    pulse_clear();
    chk("R7 cleared", {63'd0, irq}, 64'd0);
    @(negedge clk); irq_clr = 1'b1;
    do_txn(32'h0000_0040, 1'b0, 2'd2, '0, rd, er, fwd);
    @(negedge clk); irq_clr = 1'b0;
    @(negedge clk);
    chk("R6 suppressed by clear", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_size();
    logic [63:0] rd; logic er; int fwd;
    cfg_ns = 1'b0; cfg_er = 1'b0;
    for (int s = 0; s < 4; s++) begin
      do_txn(32'h4000_0000, 1'b0, 2'(s), '0, rd, er, fwd);
      chk("R9 read lanes", rd, lane_keep(PAT, s));
    end
    do_txn(32'h4000_0000, 1'b1, 2'd1, 64'hFFEE_DDCC_BBAA_9988, rd, er, fwd);
    chk("R9 write lanes", cap_wdata, 64'h0000_0000_0000_9988);
  endtask

  // R10 R11: policy change while stalled downstream
  task automatic t_cfg_stall();
    int n;
    cfg_ns = 1'b0; cfg_er = 1'b0; dn_ready = 1'b0;
    @(negedge clk);
    up_valid = 1'b1; up_addr = 32'h0000_0200; up_wr = 1'b0; up_size = 2'd3;
    @(posedge clk);
    @(negedge clk);
    up_valid = 1'b0; cfg_ns = 1'b1; cfg_er = 1'b1;
    chk("R11 busy not ready", {63'd0, up_ready}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R11 dn held", {63'd0, dn_valid}, 64'd1);
    dn_ready = 1'b1;
    n = 0;
    while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
    chk("R10 tag kept secure", {63'd0, cap_sec}, 64'd1);
    chk("R10 no error", {63'd0, rsp_err}, 64'd0);
    chk("R10 no irq", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_dn_err();
    logic [63:0] rd; logic er; int fwd;
    pulse_clear();
    cfg_ns = 1'b0; cfg_er = 1'b1; dn_err = 1'b1;
    do_txn(32'h4000_0010, 1'b1, 2'd0, '0, rd, er, fwd);
    dn_err = 1'b0;
    chk("R11 dn err relayed", {63'd0, er}, 64'd1);
    chk("R11 dn err no irq", {63'd0, irq}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_matrix();
    t_irq();
    t_size();
    t_cfg_stall();
    t_dn_err();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule